// File: doc/BRIEF.md
# Variable-Page Unified TLB Lookup and Permission Checker

This block translates a 32-bit virtual address into a 29-bit physical address using a small fully associative table. Every entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), so entries of different sizes are compared in parallel within one lookup. Matching can be filtered by an address-space identifier, and an entry flagged as shared skips that filter. A lookup that matches more than one entry is reported as a separate fault class, not resolved by priority.

Each hit is then checked against the access kind (load, store or instruction fetch), the privilege mode, the two-bit protection field and the dirty flag. The result is either a physical address with an OK flag or a 12-bit exception code. Fixed address windows skip the table: two windows are remapped by clearing the top three bits, and the top window passes through unchanged. User-mode access to these windows faults, except for a small store-queue window. A global enable switches translation off entirely. A 6-bit replacement counter steps once per table access, so software can read it to pick the slot for its next entry load. Entries are written through a dedicated one-cycle load port.

Top module: `tlbchk_lookup`

## Requirements
- R1: Page size field encodes 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. The stored VPN holds address bits 31:10. Address bits below the entry's page size are ignored in the compare, including VPN bits below that size.
- R2: An entry whose valid flag is clear never matches. An entry whose ASID differs from `cur_asid` does not match unless it is shared, or ASID filtering is off. Filtering is off only when `priv_skip_asid` is 1 and `priv_mode` is 1.
- R3: A translated lookup matching two or more entries gives fault code 0x140.
- R4: A translated lookup matching no entry gives code 0x040 for a load or fetch and 0x060 for a store. `req_kind` encodes 0 = load, 1 = store, 2 = fetch.
- R5: In user mode (`priv_mode` = 0), a hit whose protection bit 1 is clear gives 0x0A0 for a load or fetch and 0x0C0 for a store. In any mode, a store hitting an entry whose protection bit 0 is clear gives 0x0C0.
- R6: A store that passes the protection checks but hits an entry with the dirty flag clear gives code 0x080.
- R7: On a successful hit, `rsp_paddr` is the PPN page base (PPN holds physical bits 28:10, bits below the page size cleared) ORed with the virtual address bits below the page size. On any fault `rsp_ok` is 0 and `rsp_paddr` is 0.
- R8: Addresses 0x80000000–0xBFFFFFFF skip the table and have bits 31:29 cleared. Addresses at or above 0xE0000000 skip the table unchanged. In user mode, any address in these windows outside 0xE0000000–0xE3FFFFFF gives 0x0E0 for a load or fetch and 0x100 for a store.
- R9: With `xlate_en` = 0, addresses outside the R8 windows translate to their low 29 bits with OK.
- R10: `repl_ctr` advances by one on each request that reaches the table (translation on and outside the R8 windows). It wraps to 0 when the next value would exceed a nonzero `wrap_bound`, or would exceed ENTRIES-1. It holds otherwise.
- R11: The response for a request appears on the clock edge that captures the request, with `rsp_valid` high for exactly that cycle. An entry written by the load port is seen by lookups starting from the next cycle; a lookup in the same cycle sees the old contents.
- R12: After reset, all entries are invalid, `repl_ctr` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| priv_skip_asid | input | 1 | Privileged accesses ignore ASID when 1 |
| xlate_en | input | 1 | Translation enable |
| cur_asid | input | 8 | Current address-space identifier |
| wrap_bound | input | 6 | Replacement counter bound, 0 = none |
| ld_en | input | 1 | Entry load strobe |
| ld_idx | input | $clog2(ENTRIES) | Entry index to write |
| ld_vpn | input | 22 | Virtual page number (bits 31:10) |
| ld_asid | input | 8 | Entry ASID |
| ld_ppn | input | 19 | Physical page number (bits 28:10) |
| ld_size | input | 2 | Page size code |
| ld_valid | input | 1 | Entry valid flag |
| ld_shared | input | 1 | Entry shared flag |
| ld_prot | input | 2 | Protection: bit 1 user access, bit 0 write |
| ld_dirty | input | 1 | Entry dirty flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_code | output | 12 | Exception code, 0 when OK |
| rsp_paddr | output | 32 | Physical address |
| repl_ctr | output | 6 | Replacement counter |

## Verification
The checker watches on every cycle that each request gets a response on the next cycle and only then, and that the replacement counter never leaves its legal range or moves on idle cycles. It also checks that untranslated low addresses come back masked to 29 bits, and that user-mode accesses to the protected high windows always fault with one of the two address-error codes. Page-size masking, ASID and shared filtering, multi-hit detection, the order of protection, write and dirty faults, and the same-cycle load/lookup ordering depend on table contents, so only the directed scenarios can show them.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   localparam logic [11:0] EXC_NONE      = 12'h000;
   localparam logic [11:0] EXC_MISS_RD   = 12'h040;
   localparam logic [11:0] EXC_MISS_WR   = 12'h060;
   localparam logic [11:0] EXC_FIRST_WR  = 12'h080;
   localparam logic [11:0] EXC_PROT_RD   = 12'h0A0;
   localparam logic [11:0] EXC_PROT_WR   = 12'h0C0;
   localparam logic [11:0] EXC_ADDR_RD   = 12'h0E0;
   localparam logic [11:0] EXC_ADDR_WR   = 12'h100;
   localparam logic [11:0] EXC_MULTI     = 12'h140;

   typedef struct packed {
      logic        valid;
      logic        shared;
      logic [7:0]  asid;
      logic [21:0] vpn;
      logic [1:0]  size;
      logic [1:0]  prot;
      logic        dirty;
      logic [18:0] ppn;
   } tlb_entry_t;

   typedef struct packed {
      logic [1:0]  size;
      logic [1:0]  prot;
      logic        dirty;
      logic [18:0] ppn;
   } tlb_data_t;

   // Mask over VPN bits that take part in the compare for a page size.
   function automatic logic [21:0] vpn_keep(input logic [1:0] sz);
      case (sz)
         2'd0:    vpn_keep = 22'h3FFFFF;
         2'd1:    vpn_keep = 22'h3FFFFC;
         2'd2:    vpn_keep = 22'h3FFFC0;
         default: vpn_keep = 22'h3FFC00;
      endcase
   endfunction

endpackage

// File: rtl/tlbchk_slot.sv
module tlbchk_slot
   import tlbchk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  tlb_entry_t  wr_ent,
   input  logic [21:0] lk_vpn,
   input  logic [7:0]  lk_asid,
   input  logic        asid_chk,
   output logic        hit,
   output tlb_data_t   data_o
);

   tlb_entry_t ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else if (wr_en) ent_q <= wr_ent;
   end

   logic asid_ok;
   logic page_ok;

   always_comb begin
      asid_ok = !asid_chk || ent_q.shared || (ent_q.asid == lk_asid);
      page_ok = ((lk_vpn ^ ent_q.vpn) & vpn_keep(ent_q.size)) == 22'd0;
      hit     = ent_q.valid && asid_ok && page_ok;
      data_o  = '{size: ent_q.size, prot: ent_q.prot,
                  dirty: ent_q.dirty, ppn: ent_q.ppn};
   end

endmodule

// File: rtl/tlbchk_array.sv
module tlbchk_array
   import tlbchk_pkg::*;
#(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  tlb_entry_t       ld_ent,
   input  logic [21:0]      lk_vpn,
   input  logic [7:0]       lk_asid,
   input  logic             asid_chk,
   output logic             hit_any,
   output logic             hit_multi,
   output tlb_data_t        hit_data
);

   logic [ENTRIES-1:0] hits;
   tlb_data_t          slot_data [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlbchk_slot slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (ld_en && (ld_idx == IDX_W'(g))),
         .wr_ent   (ld_ent),
         .lk_vpn   (lk_vpn),
         .lk_asid  (lk_asid),
         .asid_chk (asid_chk),
         .hit      (hits[g]),
         .data_o   (slot_data[g])
      );
   end

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hits[i]) hit_data = hit_data | slot_data[i];
      end
      hit_any   = |hits;
      hit_multi = |(hits & (hits - ENTRIES'(1)));
   end

endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault
   import tlbchk_pkg::*;
(
   input  logic [31:0] vaddr,
   input  acc_kind_e   kind,
   input  logic        priv,
   input  logic        xlate_en,
   input  logic        hit_any,
   input  logic        hit_multi,
   input  tlb_data_t   hd,
   output logic        ok,
   output logic [11:0] code,
   output logic [31:0] paddr,
   output logic        tbl_access
);

   logic        low_remap;
   logic        top_pass;
   logic        sq_win;
   logic        is_st;
   logic [31:0] off_mask;
   logic [31:0] hit_pa;

   always_comb begin
      low_remap = vaddr[31:30] == 2'b10;
      top_pass  = vaddr[31:29] == 3'b111;
      sq_win    = vaddr[31:26] == 6'b111000;
      is_st     = kind == ACC_STORE;
      off_mask  = {~vpn_keep(hd.size), 10'h3FF};
      hit_pa    = ({3'b000, hd.ppn, 10'h000} & ~off_mask) | (vaddr & off_mask);

      ok         = 1'b0;
      code       = EXC_NONE;
      paddr      = '0;
      tbl_access = 1'b0;

      if (low_remap || top_pass) begin
         if (!priv && !sq_win) begin
            code = is_st ? EXC_ADDR_WR : EXC_ADDR_RD;
         end else begin
            ok    = 1'b1;
            paddr = low_remap ? {3'b000, vaddr[28:0]} : vaddr;
         end
      end else if (!xlate_en) begin
         ok    = 1'b1;
         paddr = {3'b000, vaddr[28:0]};
      end else begin
         tbl_access = 1'b1;
         if (hit_multi)                  code = EXC_MULTI;
         else if (!hit_any)              code = is_st ? EXC_MISS_WR : EXC_MISS_RD;
         else if (!priv && !hd.prot[1])  code = is_st ? EXC_PROT_WR : EXC_PROT_RD;
         else if (is_st && !hd.prot[0])  code = EXC_PROT_WR;
         else if (is_st && !hd.dirty)    code = EXC_FIRST_WR;
         else begin
            ok    = 1'b1;
            paddr = hit_pa;
         end
      end
   end

endmodule

// File: rtl/tlbchk_repl_ctr.sv
module tlbchk_repl_ctr #(
   parameter int ENTRIES = 8,
   parameter int CTR_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [CTR_W-1:0] bound,
   output logic [CTR_W-1:0] ctr
);

   localparam logic [CTR_W:0] LAST = (CTR_W+1)'(ENTRIES - 1);

   logic [CTR_W:0] nxt;
   logic           wrap;

   always_comb begin
      nxt  = {1'b0, ctr} + 1'b1;
      wrap = ((bound != '0) && (nxt > {1'b0, bound})) || (nxt > LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctr <= '0;
      else if (adv) ctr <= wrap ? '0 : nxt[CTR_W-1:0];
   end

endmodule

// File: rtl/tlbchk_lookup.sv
module tlbchk_lookup
   import tlbchk_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int CTR_W   = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [31:0]                req_vaddr,
   input  logic [1:0]                 req_kind,
   input  logic                       priv_mode,
   input  logic                       priv_skip_asid,
   input  logic                       xlate_en,
   input  logic [7:0]                 cur_asid,
   input  logic [CTR_W-1:0]           wrap_bound,
   input  logic                       ld_en,
   input  logic [$clog2(ENTRIES)-1:0] ld_idx,
   input  logic [21:0]                ld_vpn,
   input  logic [7:0]                 ld_asid,
   input  logic [18:0]                ld_ppn,
   input  logic [1:0]                 ld_size,
   input  logic                       ld_valid,
   input  logic                       ld_shared,
   input  logic [1:0]                 ld_prot,
   input  logic                       ld_dirty,
   output logic                       rsp_valid,
   output logic                       rsp_ok,
   output logic [11:0]                rsp_code,
   output logic [31:0]                rsp_paddr,
   output logic [CTR_W-1:0]           repl_ctr
);

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("tlbchk_lookup: ENTRIES must be in 2..64");
   end
   if (ENTRIES > (1 << CTR_W)) begin : g_bad_ctr
      $error("tlbchk_lookup: CTR_W too narrow for ENTRIES");
   end

   tlb_entry_t ld_ent;
   logic       asid_chk;
   logic       hit_any;
   logic       hit_multi;
   tlb_data_t  hit_data;
   logic       f_ok;
   logic [11:0] f_code;
   logic [31:0] f_paddr;
   logic        tbl_access;

   always_comb begin
      ld_ent   = '{valid: ld_valid, shared: ld_shared, asid: ld_asid,
                   vpn: ld_vpn, size: ld_size, prot: ld_prot,
                   dirty: ld_dirty, ppn: ld_ppn};
      asid_chk = !priv_skip_asid || !priv_mode;
   end

   tlbchk_array #(.ENTRIES(ENTRIES)) array_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_idx    (ld_idx),
      .ld_ent    (ld_ent),
      .lk_vpn    (req_vaddr[31:10]),
      .lk_asid   (cur_asid),
      .asid_chk  (asid_chk),
      .hit_any   (hit_any),
      .hit_multi (hit_multi),
      .hit_data  (hit_data)
   );

   tlbchk_fault fault_i (
      .vaddr      (req_vaddr),
      .kind       (acc_kind_e'(req_kind)),
      .priv       (priv_mode),
      .xlate_en   (xlate_en),
      .hit_any    (hit_any),
      .hit_multi  (hit_multi),
      .hd         (hit_data),
      .ok         (f_ok),
      .code       (f_code),
      .paddr      (f_paddr),
      .tbl_access (tbl_access)
   );

   tlbchk_repl_ctr #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (req_valid && tbl_access),
      .bound (wrap_bound),
      .ctr   (repl_ctr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_code  <= '0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_ok    <= f_ok;
            rsp_code  <= f_code;
            rsp_paddr <= f_paddr;
         end
      end
   end

endmodule

// File: rtl/tlbchk_lookup_chk.sv
module tlbchk_lookup_chk #(
   parameter int ENTRIES = 8,
   parameter int CTR_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [31:0]      req_vaddr,
   input logic             priv_mode,
   input logic             xlate_en,
   input logic             rsp_valid,
   input logic             rsp_ok,
   input logic [11:0]      rsp_code,
   input logic [31:0]      rsp_paddr,
   input logic [CTR_W-1:0] repl_ctr
);

   localparam logic [CTR_W-1:0] LAST = CTR_W'(ENTRIES - 1);

   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R11
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R10
   ctr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repl_ctr <= LAST);

   // R10
   ctr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(repl_ctr));

   // R9
   xlate_off_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlate_en && !req_vaddr[31]) |=>
         (rsp_ok && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

   // R8
   user_high_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !priv_mode && req_vaddr[31:26] >= 6'b111001) |=>
         (!rsp_ok && (rsp_code == 12'h0E0 || rsp_code == 12'h100)));

   // R7
   fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok) |-> (rsp_paddr == 32'd0 && rsp_code != 12'd0));

endmodule

bind tlbchk_lookup tlbchk_lookup_chk #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_vaddr (req_vaddr),
   .priv_mode (priv_mode),
   .xlate_en  (xlate_en),
   .rsp_valid (rsp_valid),
   .rsp_ok    (rsp_ok),
   .rsp_code  (rsp_code),
   .rsp_paddr (rsp_paddr),
   .repl_ctr  (repl_ctr)
);

// File: tb/tlbchk_lookup_tb_top.sv
module tlbchk_lookup_tb_top;

   localparam int ENTRIES = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        priv_mode = 1'b1;
   logic        priv_skip_asid = 1'b0;
   logic        xlate_en = 1'b0;
   logic [7:0]  cur_asid = 8'd5;
   logic [5:0]  wrap_bound = '0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [21:0] ld_vpn = '0;
   logic [7:0]  ld_asid = '0;
   logic [18:0] ld_ppn = '0;
   logic [1:0]  ld_size = '0;
   logic        ld_valid = 1'b0;
   logic        ld_shared = 1'b0;
   logic [1:0]  ld_prot = '0;
   logic        ld_dirty = 1'b0;
   logic        rsp_valid;
   logic        rsp_ok;
   logic [11:0] rsp_code;
   logic [31:0] rsp_paddr;
   logic [5:0]  repl_ctr;

   int checks = 0;
   int failures = 0;
   int model_ctr = 0;

   always #5 clk = ~clk;

   tlbchk_lookup #(.ENTRIES(ENTRIES)) dut_i (.*);

   localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pa_of(input logic [18:0] ppn, input logic [1:0] sz,
                                         input logic [31:0] va);
      int sh;
      logic [31:0] m;
      sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
      m  = (32'd1 << sh) - 1;
      return ({3'b000, ppn, 10'h000} & ~m) | (va & m);
   endfunction

   task automatic load_ent(input int idx, input logic [31:0] va, input logic [7:0] asid,
                           input logic [18:0] ppn, input logic [1:0] sz, input logic v,
                           input logic sh, input logic [1:0] pr, input logic d);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 3'(idx); ld_vpn = va[31:10]; ld_asid = asid;
      ld_ppn = ppn; ld_size = sz; ld_valid = v; ld_shared = sh; ld_prot = pr; ld_dirty = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   function automatic bit reaches_table(input logic [31:0] va);
      return xlate_en && !(va[31:30] == 2'b10) && !(va[31:29] == 3'b111);
   endfunction

   task automatic step_model();
      int n;
      n = model_ctr + 1;
      if ((wrap_bound != 0 && n > int'(wrap_bound)) || n > ENTRIES - 1) n = 0;
      model_ctr = n;
   endtask

   task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] kind,
                         input logic priv, input logic eok, input logic [11:0] ecode,
                         input logic [31:0] epa);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; priv_mode = priv;
      @(negedge clk);
      req_valid = 1'b0;
      if (reaches_table(va)) step_model();
      chk(req, {19'd0, rsp_valid, rsp_ok, rsp_code, rsp_paddr},
               {19'd0, 1'b1, eok, ecode, epa});
      chk("R10 counter", 64'(repl_ctr), 64'(model_ctr));
   endtask

   task automatic t_reset();
      chk("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk("R12 counter after reset", 64'(repl_ctr), 64'd0);
      xlate_en = 1'b1;
      lookup("R12 entries invalid", 32'h0040_0000, LD, 1'b1, 1'b0, 12'h040, 32'd0);
   endtask

   task automatic t_xlate_off();
      xlate_en = 1'b0;
      lookup("R9 masked", 32'h7234_5678, LD, 1'b0, 1'b1, 12'h000, 32'h1234_5678);
      lookup("R9 store masked", 32'hD000_0010, ST, 1'b0, 1'b1, 12'h000, 32'h1000_0010);
      xlate_en = 1'b1;
   endtask

   task automatic t_bypass();
      lookup("R8 low window priv", 32'h8123_4567, LD, 1'b1, 1'b1, 12'h000, 32'h0123_4567);
      lookup("R8 second window priv", 32'hA000_0010, FE, 1'b1, 1'b1, 12'h000, 32'h0000_0010);
      lookup("R8 top passthrough", 32'hF000_1234, ST, 1'b1, 1'b1, 12'h000, 32'hF000_1234);
      lookup("R8 user load err", 32'h8000_0000, LD, 1'b0, 1'b0, 12'h0E0, 32'd0);
      lookup("R8 user fetch err", 32'hB000_0000, FE, 1'b0, 1'b0, 12'h0E0, 32'd0);
      lookup("R8 user store err", 32'hF000_0000, ST, 1'b0, 1'b0, 12'h100, 32'd0);
      lookup("R8 user store queue ok", 32'hE000_0040, ST, 1'b0, 1'b1, 12'h000, 32'hE000_0040);
   endtask

   task automatic t_sizes();
      load_ent(0, 32'h0040_0000, 8'd5, 19'h00123, 2'd0, 1, 0, 2'b11, 1);
      load_ent(1, 32'h1000_0000, 8'd5, 19'h02345, 2'd1, 1, 0, 2'b11, 1);
      load_ent(2, 32'h2000_0000, 8'd5, 19'h0ABCD, 2'd2, 1, 0, 2'b11, 1);
      load_ent(3, 32'h300F_FC00, 8'd5, 19'h7FFFF, 2'd3, 1, 0, 2'b11, 1);
      cur_asid = 8'd5;
      lookup("R1 R7 1K hit", 32'h0040_0123, LD, 1'b0, 1'b1, 12'h000, pa_of(19'h00123, 0, 32'h0040_0123));
      lookup("R1 1K next page miss", 32'h0040_0400, LD, 1'b0, 1'b0, 12'h040, 32'd0);
      lookup("R1 R7 4K hit", 32'h1000_0ABC, FE, 1'b0, 1'b1, 12'h000, pa_of(19'h02345, 1, 32'h1000_0ABC));
      lookup("R1 R7 64K hit", 32'h2000_F00D, LD, 1'b0, 1'b1, 12'h000, pa_of(19'h0ABCD, 2, 32'h2000_F00D));
      lookup("R1 R7 1M hit masked vpn", 32'h3008_1234, ST, 1'b0, 1'b1, 12'h000, 32'h1FF8_1234);
   endtask

   task automatic t_asid();
      load_ent(4, 32'h4000_0000, 8'd9, 19'h00400, 2'd1, 1, 1, 2'b11, 1);
      load_ent(5, 32'h5000_0000, 8'd6, 19'h00500, 2'd1, 0, 0, 2'b11, 1);
      cur_asid = 8'd6;
      priv_skip_asid = 1'b0;
      lookup("R2 asid mismatch user", 32'h1000_0010, LD, 1'b0, 1'b0, 12'h040, 32'd0);
      lookup("R2 shared overrides asid", 32'h4000_0020, LD, 1'b0, 1'b1, 12'h000, pa_of(19'h00400, 1, 32'h4000_0020));
      lookup("R2 priv with filter on", 32'h1000_0010, LD, 1'b1, 1'b0, 12'h040, 32'd0);
      priv_skip_asid = 1'b1;
      lookup("R2 priv filter off", 32'h1000_0010, LD, 1'b1, 1'b1, 12'h000, pa_of(19'h02345, 1, 32'h1000_0010));
      lookup("R2 user still filtered", 32'h1000_0010, LD, 1'b0, 1'b0, 12'h040, 32'd0);
      lookup("R2 R4 invalid no match store", 32'h5000_0000, ST, 1'b1, 1'b0, 12'h060, 32'd0);
      lookup("R4 fetch miss", 32'h5000_0000, FE, 1'b1, 1'b0, 12'h040, 32'd0);
      priv_skip_asid = 1'b0;
      cur_asid = 8'd5;
   endtask

   task automatic t_perm();
      load_ent(6, 32'h6000_0000, 8'd5, 19'h00600, 2'd1, 1, 0, 2'b01, 1);
      load_ent(7, 32'h7000_0000, 8'd5, 19'h00700, 2'd1, 1, 0, 2'b10, 1);
      lookup("R5 user load no access", 32'h6000_0004, LD, 1'b0, 1'b0, 12'h0A0, 32'd0);
      lookup("R5 user fetch no access", 32'h6000_0004, FE, 1'b0, 1'b0, 12'h0A0, 32'd0);
      lookup("R5 user store no access", 32'h6000_0004, ST, 1'b0, 1'b0, 12'h0C0, 32'd0);
      lookup("R5 priv load allowed", 32'h6000_0004, LD, 1'b1, 1'b1, 12'h000, pa_of(19'h00600, 1, 32'h6000_0004));
      lookup("R5 user store read-only", 32'h7000_0008, ST, 1'b0, 1'b0, 12'h0C0, 32'd0);
      lookup("R5 priv store read-only", 32'h7000_0008, ST, 1'b1, 1'b0, 12'h0C0, 32'd0);
      lookup("R5 user load read-only ok", 32'h7000_0008, LD, 1'b0, 1'b1, 12'h000, pa_of(19'h00700, 1, 32'h7000_0008));
      load_ent(5, 32'h5000_0000, 8'd5, 19'h00500, 2'd1, 1, 0, 2'b11, 0);
      lookup("R6 first write", 32'h5000_0010, ST, 1'b0, 1'b0, 12'h080, 32'd0);
      lookup("R6 load on clean ok", 32'h5000_0010, LD, 1'b0, 1'b1, 12'h000, pa_of(19'h00500, 1, 32'h5000_0010));
   endtask

   task automatic t_multi();
      load_ent(5, 32'h1000_0000, 8'd5, 19'h00999, 2'd3, 1, 0, 2'b11, 1);
      lookup("R3 multi hit load", 32'h1000_0010, LD, 1'b1, 1'b0, 12'h140, 32'd0);
      lookup("R3 multi hit store", 32'h1000_0010, ST, 1'b0, 1'b0, 12'h140, 32'd0);
      lookup("R3 single hit elsewhere in 1M", 32'h1004_0010, LD, 1'b1, 1'b1, 12'h000, pa_of(19'h00999, 3, 32'h1004_0010));
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 3'd0; ld_vpn = 22'h001000; ld_asid = 8'd5; ld_ppn = 19'h00456;
      ld_size = 2'd0; ld_valid = 1'b1; ld_shared = 1'b0; ld_prot = 2'b11; ld_dirty = 1'b1;
      req_valid = 1'b1; req_vaddr = 32'h0040_0123; req_kind = LD; priv_mode = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; req_valid = 1'b0;
      step_model();
      chk("R11 same-cycle sees old entry", 64'(rsp_paddr), 64'(pa_of(19'h00123, 0, 32'h0040_0123)));
      @(negedge clk);
      chk("R11 rsp_valid one cycle only", 64'(rsp_valid), 64'd0);
      lookup("R11 new entry visible", 32'h0040_0123, LD, 1'b1, 1'b1, 12'h000, pa_of(19'h00456, 0, 32'h0040_0123));
   endtask

   task automatic t_counter();
      wrap_bound = 6'd3;
      for (int i = 0; i < 6; i++)
         lookup("R10 bounded wrap", 32'h0040_0000, LD, 1'b1, 1'b1, 12'h000, pa_of(19'h00456, 0, 32'h0040_0000));
      wrap_bound = 6'd0;
      for (int i = 0; i < 9; i++)
         lookup("R10 wrap at last index", 32'h5100_0000, FE, 1'b1, 1'b0, 12'h040, 32'd0);
      lookup("R10 bypass no advance", 32'h8000_0100, LD, 1'b1, 1'b1, 12'h000, 32'h0000_0100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_xlate_off();
      t_bypass();
      t_sizes();
      t_asid();
      t_perm();
      t_multi();
      t_same_cycle();
      t_counter();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule